// File: doc/BRIEF.md
# Serial Clock Divider with Enable Handshake

This block derives a serial bus clock from the main clock for a serial peripheral master. The division is done in two stages. A power-of-two prescaler first turns the main clock into a tick stream at one of four rates. A reload counter then counts those ticks and toggles the serial clock. A 2-bit prescale field and a 6-bit baud field select the ratio. Too small a baud value is raised to the lowest legal value. A polarity bit sets the level at which the clock rests between transfers.

The shift engine beside this block does not watch the serial clock itself. It uses two one-cycle strobes, one for the leading edge and one for the trailing edge of each serial clock period. The divider fields and the polarity bit are taken only while the device enable is low. After enable rises, a ready bit comes up a fixed number of cycles later, and software waits for it. Edges are produced only while `run` is high and the device is ready.

Top module: `spiclk_gen`

## Requirements
- R1: While reset is held and right after it is released, `sck_o`, `lead_stb_o`, `trail_stb_o` and `rdy_o` are all 0.
- R2: `rdy_o` goes to 1 at the second rising clock edge at which `dev_en` is sampled high. It returns to 0 in the same cycle that `dev_en` goes low, before any clock edge.
- R3: A baud field value below 4 (0 to 3) divides exactly as a value of 4 does.
- R4: Each half period of `sck_o` lasts (2 << presc) × (baud + 1) main-clock cycles. The full period is twice that: 20 cycles for presc 0 and baud 4, and 2048 cycles for presc 3 and baud 63.
- R5: `lead_stb_o` is high for exactly one cycle, the first cycle in which `sck_o` has left its idle level. `trail_stb_o` is high for exactly one cycle, the first cycle in which `sck_o` is back at its idle level.
- R6: While no edges are running, `sck_o` equals the captured polarity bit (1 = rests high, 0 = rests low). No strobe fires while `run` is low or `rdy_o` is low.
- R7: The prescale, baud and polarity inputs are captured at each clock edge at which `dev_en` is low. Changes made to them while `dev_en` is high have no effect on the clock.
- R8: After `run` is first sampled high with the device ready, the first leading strobe comes on the half-period-th rising edge, counting that first edge as 1.
- R9: When `run` drops, `sck_o` returns to its idle level at the next rising edge and no trailing strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_en | input | 1 | Device enable; configuration is captured while low |
| run | input | 1 | Transfer active; allows serial clock edges |
| presc_i | input | 2 | Prescale select, main clock divided by 2 << presc_i |
| baud_i | input | 6 | Baud reload value, raised to 4 when smaller |
| cinv_i | input | 1 | Idle level of the serial clock |
| sck_o | output | 1 | Serial clock |
| lead_stb_o | output | 1 | One-cycle strobe on the leading serial clock edge |
| trail_stb_o | output | 1 | One-cycle strobe on the trailing serial clock edge |
| rdy_o | output | 1 | Device ready status |

## Verification
The embedded properties depend on one condition: the captured configuration does not move while the device is enabled. The counter range checks and the idle-level checks rely on it. The stimulus therefore changes prescale, baud and polarity only while `dev_en` is low, waits one edge for them to be captured, and only then raises `dev_en`. The single exception is a deliberate change made while enabled, which is there to show that the change is ignored. All inputs, including `run`, are driven at falling edges, so each is sampled cleanly at the following rising edge.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;
  localparam int DIV_W   = 2;
  localparam int BRG_W   = 6;
  localparam int BRG_MIN = 4;
  localparam int RDY_CYC = 2;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [BRG_W-1:0] brg;
    logic             cinv;
  } spiclk_cfg_t;
endpackage

// File: rtl/spiclk_cfg.sv
module spiclk_cfg
  import spiclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_en,
  input  logic [DIV_W-1:0] div_i,
  input  logic [BRG_W-1:0] brg_i,
  input  logic             cinv_i,
  output spiclk_cfg_t      cfg_o
);
  spiclk_cfg_t cfg_q, cfg_n;
  logic        cap_en;

  assign cap_en = ~dev_en;

  always_comb begin
    cfg_n      = cfg_q;
    cfg_n.div  = div_i;
    cfg_n.brg  = (brg_i < BRG_W'(BRG_MIN)) ? BRG_W'(BRG_MIN) : brg_i;
    cfg_n.cinv = cinv_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.div  <= '0;
      cfg_q.brg  <= BRG_W'(BRG_MIN);
      cfg_q.cinv <= 1'b0;
    end else if (cap_en) begin
      cfg_q <= cfg_n;
    end
  end

  assign cfg_o = cfg_q;

  // R7: configuration frozen while enabled
  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_en |=> $stable(cfg_q));
  // R3: captured baud value never below the floor
  p_brg_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.brg >= BRG_W'(BRG_MIN));
endmodule

// File: rtl/spiclk_ready.sv
module spiclk_ready #(
  parameter int RDY_CYC = spiclk_pkg::RDY_CYC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_en,
  output logic rdy_o
);
  localparam int RC_W = $clog2(RDY_CYC + 1);

  logic [RC_W-1:0] cnt_q, cnt_n;
  logic            done;

  assign done = (cnt_q == RC_W'(RDY_CYC));

  always_comb begin
    cnt_n = cnt_q;
    if (!dev_en)   cnt_n = '0;
    else if (!done) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign rdy_o = dev_en & done;

  // R2: ready only appears after enable was already sampled high
  p_rdy_after_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_o) |-> $past(dev_en));
endmodule

// File: rtl/spiclk_presc.sv
module spiclk_presc
  import spiclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int PCNT_W = 2 ** DIV_W;

  logic [PCNT_W-1:0] pcnt_q, pcnt_n;
  logic [PCNT_W:0]   lim;
  logic              last;

  assign lim  = (PCNT_W+1)'(2) << div_i;
  assign last = (pcnt_q == PCNT_W'(lim - 1'b1));
  assign tick_o = active & last;

  always_comb begin
    pcnt_n = pcnt_q;
    if (!active)   pcnt_n = '0;
    else if (last) pcnt_n = '0;
    else           pcnt_n = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_n;
  end

  // R4: prescale count stays below its selected divisor
  p_pcnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ({1'b0, pcnt_q} < lim));
endmodule

// File: rtl/spiclk_baud.sv
module spiclk_baud
  import spiclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick_i,
  input  logic [BRG_W-1:0] brg_i,
  output logic             phase_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic [BRG_W-1:0] bcnt_q, bcnt_n;
  logic             phase_q, phase_n;
  logic             lead_q, lead_n, trail_q, trail_n;
  logic             flip;

  assign flip = tick_i & (bcnt_q == brg_i);

  always_comb begin
    bcnt_n  = bcnt_q;
    phase_n = phase_q;
    lead_n  = 1'b0;
    trail_n = 1'b0;
    if (!active) begin
      bcnt_n  = '0;
      phase_n = 1'b0;
    end else if (flip) begin
      bcnt_n  = '0;
      phase_n = ~phase_q;
      lead_n  = ~phase_q;
      trail_n = phase_q;
    end else if (tick_i) begin
      bcnt_n = bcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q  <= '0;
      phase_q <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      bcnt_q  <= bcnt_n;
      phase_q <= phase_n;
      lead_q  <= lead_n;
      trail_q <= trail_n;
    end
  end

  assign phase_o = phase_q;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;

  // R4: reload counter never passes the baud value
  p_bcnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt_q <= brg_i);
  // R5: a leading strobe leaves the phase active, a trailing one idle
  p_lead_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lead_q |-> phase_q);
  p_trail_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trail_q |-> !phase_q);
endmodule

// File: rtl/spiclk_gen.sv
module spiclk_gen
  import spiclk_pkg::*;
#(
  parameter int RDY_DELAY = spiclk_pkg::RDY_CYC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_en,
  input  logic             run,
  input  logic [DIV_W-1:0] presc_i,
  input  logic [BRG_W-1:0] baud_i,
  input  logic             cinv_i,
  output logic             sck_o,
  output logic             lead_stb_o,
  output logic             trail_stb_o,
  output logic             rdy_o
);
  spiclk_cfg_t cfg;
  logic        rdy;
  logic        active;
  logic        tick;
  logic        phase;

  spiclk_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .dev_en (dev_en),
    .div_i  (presc_i),
    .brg_i  (baud_i),
    .cinv_i (cinv_i),
    .cfg_o  (cfg)
  );

  spiclk_ready #(.RDY_CYC(RDY_DELAY)) u_rdy (
    .clk    (clk),
    .rst_n  (rst_n),
    .dev_en (dev_en),
    .rdy_o  (rdy)
  );

  assign active = run & rdy;

  spiclk_presc u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .div_i  (cfg.div),
    .tick_o (tick)
  );

  spiclk_baud u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .tick_i  (tick),
    .brg_i   (cfg.brg),
    .phase_o (phase),
    .lead_o  (lead_stb_o),
    .trail_o (trail_stb_o)
  );

  assign sck_o = phase ^ cfg.cinv;
  assign rdy_o = rdy;

  // R6 / R9: without run and ready the clock rests and strobes stay low
  p_idle_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (sck_o == cfg.cinv) && !lead_stb_o && !trail_stb_o);
  // R5: leading strobe coincides with the non-idle level at the port
  p_lead_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb_o |-> (sck_o != cfg.cinv));
  p_stb_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_stb_o, trail_stb_o}));
  // R2: ready drops with enable
  p_rdy_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_en |-> !rdy_o);
endmodule

// File: tb/sim_spiclk_gen.sv
module sim_spiclk_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       dev_en, run, cinv;
  logic [1:0] presc;
  logic [5:0] baud;
  logic       sck, lead, trail, rdy;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  spiclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .dev_en(dev_en), .run(run),
    .presc_i(presc), .baud_i(baud), .cinv_i(cinv),
    .sck_o(sck), .lead_stb_o(lead), .trail_stb_o(trail), .rdy_o(rdy)
  );

  // {presc[2], baud[6], cinv[1], half period[12]}
  localparam int NV = 8;
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 6'd4,  1'b0, 12'd10},
    {2'd0, 6'd0,  1'b1, 12'd10},
    {2'd0, 6'd3,  1'b0, 12'd10},
    {2'd1, 6'd7,  1'b0, 12'd32},
    {2'd2, 6'd10, 1'b1, 12'd88},
    {2'd3, 6'd3,  1'b1, 12'd80},
    {2'd1, 6'd63, 1'b1, 12'd256},
    {2'd3, 6'd63, 1'b0, 12'd1024}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wait_stb(input bit want_lead, output int n, output bit other);
    n = 0; other = 0;
    do begin
      step(); n++;
      if (want_lead ? trail : lead) other = 1;
    end while (!(want_lead ? lead : trail) && n < 5000);
  endtask

  task automatic configure(input logic [1:0] p, input logic [5:0] b, input logic c);
    dev_en = 0; run = 0; step();
    presc = p; baud = b; cinv = c; step();
    dev_en = 1; step(); step();
  endtask

  initial begin
    for (int w = 0; w < 190000; w++) @(posedge clk);
    if (!ended) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n; bit oth;
    rst_n = 0; dev_en = 0; run = 0; presc = 0; baud = 0; cinv = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sck == 0 && lead == 0 && trail == 0 && rdy == 0, "R1 in reset", {sck, lead, trail, rdy}, 0);
    rst_n = 1; step();
    chk(lead == 0 && trail == 0 && rdy == 0, "R1 after release", {lead, trail, rdy}, 0);

    // table walk: R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      logic [1:0] p; logic [5:0] b; logic c; int h;
      {p, b, c} = VEC[i][20:12];
      h = int'(VEC[i][11:0]);
      configure(p, b, c);
      chk(rdy == 1, "R2 ready before run", rdy, 1);
      chk(sck == c, "R6 idle level", sck, c);
      run = 1;
      wait_stb(1, n, oth);
      chk(n == h && !oth, "R8 R3 first lead delay", n, h);
      chk(sck == !c, "R5 level at lead", sck, !c);
      step();
      chk(lead == 0, "R5 lead one cycle", lead, 0);
      wait_stb(0, n, oth);
      chk(n == h - 1 && !oth, "R4 half period to trail", n + 1, h);
      chk(sck == c, "R5 level at trail", sck, c);
      wait_stb(1, n, oth);
      chk(n == h && !oth, "R4 trail to lead", n, h);
      run = 0; step();
      chk(sck == c && trail == 0, "R9 stop mid period", {sck, trail}, {c, 1'b0});
      repeat (3 * h) begin
        step();
        if (lead || trail || sck != c) begin
          chk(0, "R6 no edges when run low", {lead, trail, sck}, {2'b00, c});
          break;
        end
      end
      total++;
    end

    // R2: ready timing and immediate fall
    dev_en = 0; run = 0; step();
    presc = 0; baud = 4; cinv = 0; step();
    dev_en = 1; step();
    chk(rdy == 0, "R2 not ready after one edge", rdy, 0);
    step();
    chk(rdy == 1, "R2 ready after two edges", rdy, 1);
    @(posedge clk); #2; dev_en = 0; #1;
    chk(rdy == 0, "R2 immediate fall", rdy, 0);
    @(negedge clk);

    // R6: run while not enabled produces nothing
    run = 1;
    oth = 0;
    repeat (40) begin
      step();
      if (lead || trail || sck != 0) oth = 1;
    end
    chk(!oth, "R6 run while disabled", oth, 0);
    run = 0;

    // R7: baud change while enabled ignored
    configure(2'd0, 6'd4, 1'b0);
    baud = 6'd30; presc = 2'd3; cinv = 1'b1; step();
    chk(sck == 0, "R7 polarity change ignored", sck, 0);
    run = 1;
    wait_stb(1, n, oth);
    chk(n == 10, "R7 divider change ignored", n, 10);
    run = 0; step();

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule